// File: doc/BRIEF.md
# Equalizer Acquisition Averager

This block runs one measurement pass for a single trial equalizer setting on a three-lane TMDS receiver. When it is started, it turns the setting index into a one-hot lock vector and drives that vector to all three lane equalizers. It then repeats a fixed loop: raise a one-cycle calibration trigger, wait for an external settle tick, and capture each lane's 16-bit early-count value. The first capture follows a long settle period. Every later capture follows a short one. The block only asks for the right period through `long_settle`; the timer that measures it lives outside the block.

The first capture on each lane sets an acceptance window for that lane, 20 counts wide on each side. When more than three samples are requested and the second and third samples on every lane stay inside their lane's own window, the pass ends after three samples. Otherwise it takes all N samples. Each lane's sum is then divided by the number of samples used, using a shared-timing bit-serial divider. The three averages are presented together with a one-cycle `done` pulse.

The controller is a six-state machine:
- IDLE: wait for `start`.
- TRIG: issue the calibration pulse.
- WAIT: hold for the settle tick. The tick captures a sample.
- EVAL: decide whether to loop back to TRIG or move to DIV. It moves to DIV when N samples are taken, or at the early-stop point.
- DIV: hold until all dividers finish.
- DONE: pulse `done`, then return to IDLE.

Top module: `eqacq_averager`

## Requirements
- R1: From the cycle after an accepted `start` until the next accepted `start`, `lock_vec` equals 1 shifted left by `setting`, so bit `setting` is the only bit set. After reset `lock_vec` is all zero.
- R2: Each sample is preceded by exactly one `cal_pulse` that is high for a single cycle. A pass issues as many pulses as samples it uses.
- R3: While the block waits for the first settle tick of a pass, `long_settle` is 1. While it waits for any later tick, `long_settle` is 0.
- R4: The three early-count inputs are captured only on a cycle where `settle_tick` is high while waiting. Ticks and count changes at any other time have no effect on the outputs.
- R5: Each lane's window is built from that lane's first sample. The upper limit is the first sample plus 20. The lower limit is the first sample minus 20, clamped at 0. A sample is out of window when it is strictly above the upper limit or strictly below the lower limit. Each lane uses only its own window.
- R6: If the effective N is greater than 3 and samples 2 and 3 on all lanes are inside their windows, the pass stops after 3 samples, 3 cal pulses are issued, and each average is floor(sum of 3 samples / 3).
- R7: Otherwise the pass takes N samples and each average is floor(sum of N samples / N).
- R8: A requested N of 0 is treated as 1.
- R9: `done` is high for exactly one cycle per pass. The averages change only when a pass completes, and they hold their values between passes.
- R10: `start` is ignored while a pass is in progress. It neither restarts the pass nor changes `lock_vec`.
- R11: The accumulators cannot overflow. With N = 255 samples of 65535, every average is 65535.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass (accepted only in IDLE) |
| setting | input | 4 | Trial equalizer setting index, 0 to 13 |
| num_samples | input | 8 | Requested number of samples N (0 means 1) |
| settle_tick | input | 1 | Settle period elapsed; captures the counts while waiting |
| early_cnt0 | input | 16 | Lane 0 early-count value |
| early_cnt1 | input | 16 | Lane 1 early-count value |
| early_cnt2 | input | 16 | Lane 2 early-count value |
| lock_vec | output | 14 | One-hot lock vector shared by all lanes |
| cal_pulse | output | 1 | One-cycle auto-calibration trigger |
| long_settle | output | 1 | High while the first (long) settle period is awaited |
| avg0 | output | 16 | Lane 0 average |
| avg1 | output | 16 | Lane 1 average |
| avg2 | output | 16 | Lane 2 average |
| done | output | 1 | One-cycle completion pulse |

## Verification
The one-hot check on `lock_vec` assumes `setting` never exceeds 13, because a larger index would shift the bit out of the vector. The bench only applies indices 0 to 13. The divider checks rely on the divisor never being zero. That holds because the controller always captures at least one sample before it divides, so the bench also exercises a requested N of 0. The counts are assumed steady on the tick cycle. The bench changes them only on the falling edge where it raises the tick, and it deliberately toggles the tick and the counts while the block is idle to show they are ignored.

// File: rtl/eqacq_pkg.sv
package eqacq_pkg;
    localparam int NUM_LANES = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TRIG,
        ST_WAIT,
        ST_EVAL,
        ST_DIV,
        ST_DONE
    } eqacq_state_e;
endpackage

// File: rtl/eqacq_ctrl.sv
module eqacq_ctrl
    import eqacq_pkg::*;
#(
    parameter int NUM_SET = 14,
    parameter int SAMP_W  = 8,
    parameter int EARLY_N = 3,
    localparam int SEL_W  = $clog2(NUM_SET)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SEL_W-1:0]   setting,
    input  logic [SAMP_W-1:0]  num_samples,
    input  logic               settle_tick,
    input  logic               any_oob,
    input  logic               div_done,
    output logic [NUM_SET-1:0] lock_vec,
    output logic               cal_pulse,
    output logic               long_settle,
    output logic               sample_en,
    output logic               first_sample,
    output logic               div_start,
    output logic               done,
    output logic [SAMP_W-1:0]  used_cnt
);
    eqacq_state_e state_q, state_d;
    logic [SAMP_W-1:0]  n_eff_q;
    logic [SAMP_W-1:0]  cnt_q;
    logic [NUM_SET-1:0] lock_q;
    logic               early_ok;
    logic               all_taken;

    assign early_ok  = (cnt_q == SAMP_W'(EARLY_N)) && (n_eff_q > SAMP_W'(EARLY_N)) && !any_oob;
    assign all_taken = (cnt_q == n_eff_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pass bookkeeping: setting latch, sample target, sample count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q  <= '0;
            n_eff_q <= SAMP_W'(1);
            cnt_q   <= '0;
        end else if (state_q == ST_IDLE && start) begin
            lock_q  <= NUM_SET'(1) << setting;
            n_eff_q <= (num_samples == '0) ? SAMP_W'(1) : num_samples;
            cnt_q   <= '0;
        end else if (sample_en) begin
            cnt_q   <= cnt_q + SAMP_W'(1);
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)       state_d = ST_TRIG;
            ST_TRIG:                  state_d = ST_WAIT;
            ST_WAIT: if (settle_tick) state_d = ST_EVAL;
            ST_EVAL: begin
                if (all_taken || early_ok) state_d = ST_DIV;
                else                       state_d = ST_TRIG;
            end
            ST_DIV:  if (div_done)    state_d = ST_DONE;
            ST_DONE:                  state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cal_pulse    = (state_q == ST_TRIG);
        long_settle  = (state_q == ST_WAIT) && (cnt_q == '0);
        sample_en    = (state_q == ST_WAIT) && settle_tick;
        first_sample = (cnt_q == '0);
        div_start    = (state_q == ST_EVAL) && (all_taken || early_ok);
        done         = (state_q == ST_DONE);
        lock_vec     = lock_q;
        used_cnt     = cnt_q;
    end

    // R1
    lock_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> ($countones(lock_vec) == 1));

    // R10
    lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(lock_vec));

    // R2
    cal_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_pulse |=> !cal_pulse);

    // R7
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= n_eff_q);

    // R6
    early_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_start && cnt_q != n_eff_q) |-> (cnt_q == SAMP_W'(EARLY_N)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/eqacq_lane.sv
module eqacq_lane #(
    parameter int CNT_W = 16,
    parameter int SUM_W = 24,
    parameter int WIN   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             first,
    input  logic [CNT_W-1:0] sample,
    output logic [SUM_W-1:0] sum,
    output logic             oob
);
    localparam int BND_W = CNT_W + 1;

    logic [SUM_W-1:0] sum_q;
    logic [BND_W-1:0] lo_q, hi_q;
    logic [BND_W-1:0] lo_new, hi_new, smp_ext;
    logic             oob_q;
    logic             outside;

    assign smp_ext = {1'b0, sample};
    assign lo_new  = (smp_ext >= BND_W'(WIN)) ? (smp_ext - BND_W'(WIN)) : '0;
    assign hi_new  = smp_ext + BND_W'(WIN);
    assign outside = (smp_ext > hi_q) || (smp_ext < lo_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
            oob_q <= 1'b0;
        end else if (capture) begin
            if (first) begin
                sum_q <= SUM_W'(sample);
                lo_q  <= lo_new;
                hi_q  <= hi_new;
                oob_q <= 1'b0;
            end else begin
                sum_q <= sum_q + SUM_W'(sample);
                if (outside) oob_q <= 1'b1;
            end
        end
    end

    assign sum = sum_q;
    assign oob = oob_q;

    // R5
    window_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_q <= hi_q) && ((hi_q - lo_q) <= BND_W'(2 * WIN)));

    // R5
    first_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && first) |=> !oob);
endmodule

// File: rtl/eqacq_div.sv
module eqacq_div #(
    parameter int NUM_W = 24,
    parameter int DEN_W = 8,
    parameter int QUO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [QUO_W-1:0] quot,
    output logic             done
);
    localparam int IT_W = $clog2(NUM_W + 1);
    localparam int PW   = NUM_W + DEN_W + 1;

    logic [DEN_W-1:0] rem_q, den_q;
    logic [NUM_W-1:0] q_q, num_q;
    logic [IT_W-1:0]  it_q;
    logic             busy_q, done_q;
    logic [DEN_W:0]   shifted, diff;
    logic             ge;

    assign shifted = {rem_q, q_q[NUM_W-1]};
    assign ge      = (shifted >= {1'b0, den_q});
    assign diff    = shifted - {1'b0, den_q};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            den_q  <= '0;
            q_q    <= '0;
            num_q  <= '0;
            it_q   <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start) begin
                rem_q  <= '0;
                q_q    <= num;
                num_q  <= num;
                den_q  <= den;
                it_q   <= IT_W'(NUM_W);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                rem_q <= ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                q_q   <= {q_q[NUM_W-2:0], ge};
                it_q  <= it_q - IT_W'(1);
                if (it_q == IT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign quot = q_q[QUO_W-1:0];
    assign done = done_q;

    logic [PW-1:0] prod_lo, prod_hi, num_ext;
    assign prod_lo = PW'(q_q) * PW'(den_q);
    assign prod_hi = (PW'(q_q) + PW'(1)) * PW'(den_q);
    assign num_ext = PW'(num_q);

    // R8
    den_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (den != '0));

    // R7
    quot_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> ((prod_lo <= num_ext) && (prod_hi > num_ext)));
endmodule

// File: rtl/eqacq_averager.sv
module eqacq_averager
    import eqacq_pkg::*;
#(
    parameter int NUM_SET = 14,
    parameter int SAMP_W  = 8,
    parameter int CNT_W   = 16,
    parameter int WIN     = 20,
    parameter int EARLY_N = 3,
    localparam int SEL_W  = $clog2(NUM_SET),
    localparam int SUM_W  = CNT_W + SAMP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [SEL_W-1:0]   setting,
    input  logic [SAMP_W-1:0]  num_samples,
    input  logic               settle_tick,
    input  logic [CNT_W-1:0]   early_cnt0,
    input  logic [CNT_W-1:0]   early_cnt1,
    input  logic [CNT_W-1:0]   early_cnt2,
    output logic [NUM_SET-1:0] lock_vec,
    output logic               cal_pulse,
    output logic               long_settle,
    output logic [CNT_W-1:0]   avg0,
    output logic [CNT_W-1:0]   avg1,
    output logic [CNT_W-1:0]   avg2,
    output logic               done
);
    logic                 sample_en, first_sample, div_start;
    logic [SAMP_W-1:0]    used_cnt;
    logic [CNT_W-1:0]     lane_in  [NUM_LANES];
    logic [SUM_W-1:0]     lane_sum [NUM_LANES];
    logic [CNT_W-1:0]     lane_quo [NUM_LANES];
    logic [CNT_W-1:0]     avg_q    [NUM_LANES];
    logic [NUM_LANES-1:0] lane_oob, lane_done;
    logic                 any_oob, div_done;

    assign lane_in[0] = early_cnt0;
    assign lane_in[1] = early_cnt1;
    assign lane_in[2] = early_cnt2;
    assign any_oob    = |lane_oob;
    assign div_done   = &lane_done;

    eqacq_ctrl #(
        .NUM_SET (NUM_SET),
        .SAMP_W  (SAMP_W),
        .EARLY_N (EARLY_N)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .setting      (setting),
        .num_samples  (num_samples),
        .settle_tick  (settle_tick),
        .any_oob      (any_oob),
        .div_done     (div_done),
        .lock_vec     (lock_vec),
        .cal_pulse    (cal_pulse),
        .long_settle  (long_settle),
        .sample_en    (sample_en),
        .first_sample (first_sample),
        .div_start    (div_start),
        .done         (done),
        .used_cnt     (used_cnt)
    );

    for (genvar ln = 0; ln < NUM_LANES; ln++) begin : g_lane
        eqacq_lane #(
            .CNT_W (CNT_W),
            .SUM_W (SUM_W),
            .WIN   (WIN)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .capture (sample_en),
            .first   (first_sample),
            .sample  (lane_in[ln]),
            .sum     (lane_sum[ln]),
            .oob     (lane_oob[ln])
        );

        eqacq_div #(
            .NUM_W (SUM_W),
            .DEN_W (SAMP_W),
            .QUO_W (CNT_W)
        ) u_div (
            .clk   (clk),
            .rst_n (rst_n),
            .start (div_start),
            .num   (lane_sum[ln]),
            .den   (used_cnt),
            .quot  (lane_quo[ln]),
            .done  (lane_done[ln])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)        avg_q[ln] <= '0;
            else if (div_done) avg_q[ln] <= lane_quo[ln];
        end
    end

    assign avg0 = avg_q[0];
    assign avg1 = avg_q[1];
    assign avg2 = avg_q[2];

    // R9
    avg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(div_done) |-> ($stable(avg0) && $stable(avg1) && $stable(avg2)));
endmodule

// File: tb/eqacq_averager_bench.sv
module eqacq_averager_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  setting_i = '0;
    logic [7:0]  num_i = '0;
    logic        tick = 1'b0;
    logic [15:0] e0 = '0, e1 = '0, e2 = '0;
    logic [13:0] lock_vec;
    logic        cal_pulse, long_settle, done;
    logic [15:0] avg0, avg1, avg2;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int smp [3][256];

    always #5 clk = ~clk;

    eqacq_averager u_eqacq_averager (
        .clk (clk), .rst_n (rst_n), .start (start), .setting (setting_i),
        .num_samples (num_i), .settle_tick (tick),
        .early_cnt0 (e0), .early_cnt1 (e1), .early_cnt2 (e2),
        .lock_vec (lock_vec), .cal_pulse (cal_pulse), .long_settle (long_settle),
        .avg0 (avg0), .avg1 (avg1), .avg2 (avg2), .done (done)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit in_win(int ln, int i);
        int lo, hi;
        lo = (smp[ln][0] >= 20) ? smp[ln][0] - 20 : 0;
        hi = smp[ln][0] + 20;
        return (smp[ln][i] >= lo) && (smp[ln][i] <= hi);
    endfunction

    task automatic fill(input int ln, input int base, input int step);
        for (int i = 0; i < 256; i++) smp[ln][i] = (base + i * step) & 16'hFFFF;
    endtask

    task automatic run_acq(input string tag, input int setting, input int n, input bit poke);
        int neff, used, idx, pulses, guard;
        bit early, fin;
        longint sum;
        int expv [3];
        neff = (n == 0) ? 1 : n;
        early = 0;
        if (neff > 3) begin
            early = 1;
            for (int ln = 0; ln < 3; ln++)
                for (int i = 1; i < 3; i++)
                    if (!in_win(ln, i)) early = 0;
        end
        used = early ? 3 : neff;
        for (int ln = 0; ln < 3; ln++) begin
            sum = 0;
            for (int i = 0; i < used; i++) sum += smp[ln][i];
            expv[ln] = int'(sum / used);
        end
        @(negedge clk);
        setting_i = 4'(setting); num_i = 8'(n); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        idx = 0; pulses = 0; fin = 0; guard = 0;
        while (!fin && guard < 20000) begin
            guard++;
            if (done) fin = 1;
            else if (cal_pulse) begin
                pulses++;
                chk("R1 lock vector", lock_vec, 14'(1) << setting);
                @(negedge clk);
                chk("R3 long_settle", long_settle, (idx == 0));
                if (poke && idx == 1) begin
                    start = 1'b1;
                    setting_i = 4'((setting + 1) % 14);
                end
                repeat (2) @(negedge clk);
                start = 1'b0;
                e0 = 16'(smp[0][idx]); e1 = 16'(smp[1][idx]); e2 = 16'(smp[2][idx]);
                tick = 1'b1;
                @(negedge clk);
                tick = 1'b0;
                idx++;
            end else @(negedge clk);
        end
        chk({tag, " pass completed"}, fin, 1);
        chk({tag, " R2 cal pulse count"}, pulses, used);
        chk({tag, " avg0"}, avg0, expv[0]);
        chk({tag, " avg1"}, avg1, expv[1]);
        chk({tag, " avg2"}, avg2, expv[2]);
        @(negedge clk);
        chk("R9 done single cycle", done, 0);
        chk("R9 avg0 held", avg0, expv[0]);
        if (poke) chk("R10 lock unchanged after ignored start", lock_vec, 14'(1) << setting);
    endtask

    task automatic t_reset();
        chk("R1 lock vector at reset", lock_vec, 0);
        chk("R9 done at reset", done, 0);
        chk("R2 cal at reset", cal_pulse, 0);
        chk("R9 avg0 at reset", avg0, 0);
    endtask

    task automatic t_full_run();      // R7: drifting counts, no early stop
        fill(0, 1000, 50); fill(1, 800, 37); fill(2, 3000, -40);
        run_acq("R7 full run", 5, 6, 0);
    endtask

    task automatic t_early_stop();    // R6: stable counts stop after three samples
        fill(0, 500, 1); fill(1, 600, -2); fill(2, 700, 3);
        smp[0][3] = 9000;
        run_acq("R6 early stop", 9, 8, 0);
    endtask

    task automatic t_upper_edge();    // R5: +20 inside, +21 outside
        fill(0, 100, 0); fill(1, 200, 0); fill(2, 300, 0);
        smp[0][1] = 120; smp[0][2] = 120;
        run_acq("R5 upper edge inside", 2, 5, 0);
        smp[0][2] = 121;
        run_acq("R5 upper edge outside", 3, 5, 0);
    endtask

    task automatic t_lower_edge();    // R5: -20 inside, -21 outside
        fill(0, 100, 0); fill(1, 200, 0); fill(2, 300, 0);
        smp[1][1] = 180; smp[1][2] = 179;
        run_acq("R5 lower edge outside", 4, 5, 0);
        smp[1][2] = 180;
        run_acq("R5 lower edge inside", 4, 5, 0);
    endtask

    task automatic t_sat_low();       // R5: lower limit clamps at zero
        fill(0, 5, 0); fill(1, 10, 0); fill(2, 0, 0);
        smp[0][1] = 0; smp[2][2] = 20; smp[0][3] = 60000;
        run_acq("R5 clamped lower limit", 0, 6, 0);
    endtask

    task automatic t_own_bound();     // R5: each lane judged by its own window
        fill(0, 100, 0); fill(1, 100, 0); fill(2, 1000, 0);
        smp[2][1] = 1015; smp[2][2] = 985;
        run_acq("R5 per-lane window", 13, 7, 0);
    endtask

    task automatic t_small_n();       // R8, R7
        fill(0, 4321, 7); fill(1, 11, 3); fill(2, 65535, 0);
        run_acq("R8 zero treated as one", 1, 0, 0);
        run_acq("R7 one sample", 1, 1, 0);
        fill(0, 100, 0); fill(1, 100, 0); fill(2, 100, 0);
        smp[0][2] = 101;
        run_acq("R7 three samples no early path", 7, 3, 0);
    endtask

    task automatic t_ignore();        // R4, R10
        logic [15:0] a0;
        fill(0, 50, 100); fill(1, 70, 90); fill(2, 20, 300);
        run_acq("R10 start during pass", 6, 5, 1);
        a0 = avg0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            e0 = 16'(i * 999); tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            chk("R4 no pulse from idle tick", cal_pulse, 0);
            chk("R4 no done from idle tick", done, 0);
        end
        chk("R4 avg0 unchanged by idle tick", avg0, a0);
    endtask

    task automatic t_max();           // R11
        fill(0, 65535, 0); fill(1, 65535, 0); fill(2, 0, 0);
        smp[0][1] = 0; smp[1][2] = 0;
        for (int i = 3; i < 255; i++) begin smp[0][i] = 65535; smp[1][i] = 65535; end
        smp[0][1] = 65535; smp[1][2] = 65535;
        smp[2][1] = 40;
        run_acq("R11 wide sum", 12, 255, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_run();
        t_early_stop();
        t_upper_edge();
        t_lower_edge();
        t_sat_low();
        t_own_bound();
        t_small_n();
        t_ignore();
        t_max();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule